// File: doc/BRIEF.md
# Job Ring Controller

This block is the hardware half of one producer/consumer channel for an offload engine. Software places fixed-width job descriptors into an inbound ring and then rings a doorbell with the number of new entries. The controller hands the jobs to an execution unit one at a time and in strict ring order. Each handshake has two parts: a valid/descriptor output, and a single-cycle `job_done` pulse that reports the job is finished.

On each completion the controller stores the descriptor of the finished job into an outbound ring. It counts the entry as occupied and raises a completion interrupt. Software reads the outbound ring through a read port, then returns entries with a second doorbell. Both doorbells take their count from the upper half-word of the written data. Status reads report counts shifted up by eight bits. The channel starts no job until it is enabled. It also starts no job while the outbound ring is full. A doorbell that asks for more than is possible is trimmed to the possible amount and raises the error flag.

Top module: `jr_ring_ctrl`

## Requirements
- R1: After reset the free-slot register (offset 0x10) reads DEPTH<<8, the full-slot register (0x14) reads 0, the interrupt status (0x04) reads 0, the command register (0x00) reads 0, and `irq` and `job_valid` are low.
- R2: No job is presented on `job_valid` until bit 31 of a write to the command register (0x00) has been set; writing that bit as 0 stops new jobs from starting.
- R3: A write to the add-job register (0x08) raises the inbound occupied count by the value in bits 31:16; the free-slot register reports DEPTH minus that count in bits 31:8.
- R4: An add-job amount larger than the free slots is trimmed to the free slots, and bit 30 (error) of the interrupt status is set.
- R5: Jobs are presented one at a time in inbound index order, starting from index 0 after reset and wrapping from DEPTH-1 to 0; `job_desc` holds the inbound entry of the current job while `job_valid` is high.
- R6: A `job_done` pulse while `job_valid` is high writes the current descriptor to the next outbound index, adds one to the full-slot count, frees one inbound slot, and sets bit 31 (done) of the interrupt status.
- R7: A write to the job-removed register (0x0C) lowers the full-slot count by bits 31:16, trimmed to the current count; trimming sets the error bit.
- R8: No job starts while the full-slot count equals DEPTH; a job starts once a removal frees an outbound slot.
- R9: Writing ones to bits 31 or 30 of the interrupt status clears those bits, but a flag set in the same cycle stays set; `irq` is high while either bit is set.
- R10: A `job_done` pulse while `job_valid` is low changes no count and no flag.
- R11: The ring-size register (0x18) reads DEPTH<<8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |
| in_we | input | 1 | Inbound ring entry write |
| in_idx | input | log2(DEPTH) | Inbound ring entry index |
| in_wdata | input | DESC_W | Inbound descriptor |
| out_re | input | 1 | Outbound ring entry read |
| out_idx | input | log2(DEPTH) | Outbound ring entry index |
| out_rdata | output | DESC_W | Outbound descriptor, one cycle after `out_re` |
| job_valid | output | 1 | A job is being executed |
| job_desc | output | DESC_W | Descriptor of the current job |
| job_done | input | 1 | Current job finished (one-cycle pulse) |
| irq | output | 1 | Done or error flag pending |

## Verification
Two events can meet in one cycle: a job completion that sets the done flag, and a software write that clears that flag. The bench provokes this by raising `job_done` and writing 0x80000000 to the interrupt status on the same clock edge. It then reads the status back and expects the done bit to be set, with the full-slot count also advanced. Completion and a removal doorbell also meet when the outbound ring is full: a removal must let the stalled job start. The bench judges this by seeing `job_valid` rise only after the removal and by reading that job's descriptor at the expected outbound index.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;
  localparam int AMT_W  = 16;

  localparam logic [REG_AW-1:0] OFS_CMD  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_IST  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_ADD  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_RMV  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_FREE = 8'h10;
  localparam logic [REG_AW-1:0] OFS_FULL = 8'h14;
  localparam logic [REG_AW-1:0] OFS_SIZE = 8'h18;

  localparam int BIT_DONE = 31;
  localparam int BIT_ERR  = 30;
  localparam int BIT_RUN  = 31;
  localparam int AMT_LSB  = 16;
  localparam int CNT_LSB  = 8;

  typedef struct packed {
    logic done;
    logic err;
  } ist_t;
endpackage

// File: rtl/jr_ram.sv
module jr_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/jr_occ.sv
module jr_occ #(
  parameter int DEPTH   = 1024,
  parameter int AMT_W   = 16,
  parameter bit SW_ADDS = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sw_req,
  input  logic [AMT_W-1:0]           sw_amt,
  input  logic                       hw_step,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       clip
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = ((CW > AMT_W) ? CW : AMT_W) + 1;

  logic [CW-1:0] cnt_q;
  logic [EW-1:0] limit, amt, take, nxt;

  assign amt = EW'(sw_amt);

  generate
    if (SW_ADDS) begin : g_fill
      assign limit = EW'(DEPTH) - EW'(cnt_q);
      assign nxt   = EW'(cnt_q) + take - EW'(hw_step);
    end else begin : g_drain
      assign limit = EW'(cnt_q);
      assign nxt   = EW'(cnt_q) - take + EW'(hw_step);
    end
  endgenerate

  assign clip = sw_req && (amt > limit);
  assign take = !sw_req ? '0 : (clip ? limit : amt);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= CW'(nxt);
  end

  assign cnt = cnt_q;

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/jr_sched.sv
module jr_sched #(
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     have_job,
  input  logic                     have_room,
  input  logic                     done_in,
  output logic                     start,
  output logic                     busy,
  output logic [$clog2(DEPTH)-1:0] head,
  output logic                     done_acc
);
  localparam int PW = $clog2(DEPTH);

  logic          busy_q;
  logic [PW-1:0] head_q;

  assign start    = en && !busy_q && have_job && have_room;
  assign done_acc = done_in && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      head_q <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        head_q <= head_q + 1'b1;
      end else if (done_acc) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign head = head_q;

  p_hold_job_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_in) |=> (busy_q && $stable(head_q)));
  p_head_step_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> (head_q == $past(head_q) + 1'b1));
endmodule

// File: rtl/jr_ring_ctrl.sv
module jr_ring_ctrl
  import jr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DESC_W = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic                     reg_re,
  input  logic [REG_AW-1:0]        reg_addr,
  input  logic [REG_DW-1:0]        reg_wdata,
  output logic [REG_DW-1:0]        reg_rdata,
  input  logic                     in_we,
  input  logic [$clog2(DEPTH)-1:0] in_idx,
  input  logic [DESC_W-1:0]        in_wdata,
  input  logic                     out_re,
  input  logic [$clog2(DEPTH)-1:0] out_idx,
  output logic [DESC_W-1:0]        out_rdata,
  output logic                     job_valid,
  output logic [DESC_W-1:0]        job_desc,
  input  logic                     job_done,
  output logic                     irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          add_wr, rmv_wr, cmd_wr, ist_wr;
  logic          en_q;
  ist_t          ist_q, ist_set, ist_clr;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          in_clip, out_clip;
  logic          start, busy, done_acc;
  logic [PW-1:0] head, out_wp;
  logic [AMT_W-1:0] amt;
  logic          unused_wdata_bits;

  assign add_wr = reg_we && (reg_addr == OFS_ADD);
  assign rmv_wr = reg_we && (reg_addr == OFS_RMV);
  assign cmd_wr = reg_we && (reg_addr == OFS_CMD);
  assign ist_wr = reg_we && (reg_addr == OFS_IST);
  assign amt    = reg_wdata[AMT_LSB +: AMT_W];
  assign unused_wdata_bits = ^reg_wdata[AMT_LSB-1:0];

  jr_occ #(.DEPTH(DEPTH), .AMT_W(AMT_W), .SW_ADDS(1'b1)) i_in_occ (
    .clk(clk), .rst(rst), .sw_req(add_wr), .sw_amt(amt),
    .hw_step(done_acc), .cnt(in_cnt), .clip(in_clip)
  );

  jr_occ #(.DEPTH(DEPTH), .AMT_W(AMT_W), .SW_ADDS(1'b0)) i_out_occ (
    .clk(clk), .rst(rst), .sw_req(rmv_wr), .sw_amt(amt),
    .hw_step(done_acc), .cnt(out_cnt), .clip(out_clip)
  );

  jr_sched #(.DEPTH(DEPTH)) i_sched (
    .clk(clk), .rst(rst), .en(en_q),
    .have_job(in_cnt != '0), .have_room(out_cnt != CW'(DEPTH)),
    .done_in(job_done), .start(start), .busy(busy), .head(head),
    .done_acc(done_acc)
  );

  jr_ram #(.DEPTH(DEPTH), .W(DESC_W)) i_in_ram (
    .clk(clk), .we(in_we), .waddr(in_idx), .wdata(in_wdata),
    .re(start), .raddr(head), .rdata(job_desc)
  );

  jr_ram #(.DEPTH(DEPTH), .W(DESC_W)) i_out_ram (
    .clk(clk), .we(done_acc), .waddr(out_wp), .wdata(job_desc),
    .re(out_re), .raddr(out_idx), .rdata(out_rdata)
  );

  assign ist_set.done = done_acc;
  assign ist_set.err  = in_clip || out_clip;
  assign ist_clr.done = ist_wr && reg_wdata[BIT_DONE];
  assign ist_clr.err  = ist_wr && reg_wdata[BIT_ERR];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      ist_q  <= '0;
      out_wp <= '0;
    end else begin
      if (cmd_wr)   en_q   <= reg_wdata[BIT_RUN];
      if (done_acc) out_wp <= out_wp + 1'b1;
      ist_q <= (ist_q & ~ist_clr) | ist_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        OFS_CMD:  reg_rdata <= {en_q, 31'b0};
        OFS_IST:  reg_rdata <= {ist_q.done, ist_q.err, 30'b0};
        OFS_FREE: reg_rdata <= 32'(CW'(DEPTH) - in_cnt) << CNT_LSB;
        OFS_FULL: reg_rdata <= 32'(out_cnt) << CNT_LSB;
        OFS_SIZE: reg_rdata <= 32'(DEPTH) << CNT_LSB;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign job_valid = busy;
  assign irq       = ist_q.done || ist_q.err;

  p_start_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(job_valid) |-> $past(en_q));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(job_valid) |-> ($past(out_cnt) != CW'(DEPTH)));
  p_done_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (job_done && job_valid) |=> ist_q.done);
  p_clip_err_r4: assert property (@(posedge clk) disable iff (rst)
    (add_wr && (amt > AMT_W'(DEPTH))) |=> ist_q.err);
  p_idle_done_r10: assert property (@(posedge clk) disable iff (rst)
    (job_done && !job_valid && !rmv_wr) |=> $stable(out_cnt));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (job_done && job_valid && ist_wr) |=> ist_q.done);
endmodule

// File: tb/test_jr_ring_ctrl.sv
module test_jr_ring_ctrl;
  localparam int D  = 8;
  localparam int DW = 128;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic in_we = 1'b0;
  logic [PW-1:0] in_idx = '0;
  logic [DW-1:0] in_wdata = '0;
  logic out_re = 1'b0;
  logic [PW-1:0] out_idx = '0;
  logic [DW-1:0] out_rdata;
  logic job_valid, irq;
  logic [DW-1:0] job_desc;
  logic job_done = 1'b0;

  int tests = 0, fails = 0;
  int owp = 0;
  logic [31:0] rv;
  logic [DW-1:0] dv;

  always #4 clk = ~clk;

  jr_ring_ctrl #(.DEPTH(D), .DESC_W(DW)) i_jr_ring_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_we(in_we), .in_idx(in_idx), .in_wdata(in_wdata),
    .out_re(out_re), .out_idx(out_idx), .out_rdata(out_rdata),
    .job_valid(job_valid), .job_desc(job_desc), .job_done(job_done),
    .irq(irq)
  );

  function automatic logic [DW-1:0] mk(input int k);
    return {4{32'hD0C0_0000 + 32'(k)}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic in_write(input int i, input logic [DW-1:0] d);
    @(negedge clk); in_we = 1'b1; in_idx = PW'(i); in_wdata = d;
    @(negedge clk); in_we = 1'b0;
  endtask

  task automatic out_read(input int i, output logic [DW-1:0] d);
    @(negedge clk); out_re = 1'b1; out_idx = PW'(i);
    @(negedge clk); out_re = 1'b0; d = out_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_job(input logic [DW-1:0] exp);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (job_valid) break;
    end
    chk(job_valid == 1'b1, "R5 job presented", DW'(job_valid), DW'(1));
    chk(job_desc == exp, "R5 job order", job_desc, exp);
    job_done = 1'b1;
    @(negedge clk); job_done = 1'b0;
    owp = (owp + 1) % D;
  endtask

  task automatic t_reset;
    reg_read(8'h10, rv); chk(rv == 32'(D) << 8, "R1 free", DW'(rv), DW'(D << 8));
    reg_read(8'h14, rv); chk(rv == 0, "R1 full", DW'(rv), 0);
    reg_read(8'h04, rv); chk(rv == 0, "R1 status", DW'(rv), 0);
    reg_read(8'h00, rv); chk(rv == 0, "R1 command", DW'(rv), 0);
    chk(!irq && !job_valid, "R1 pins", DW'({irq, job_valid}), 0);
    reg_read(8'h18, rv); chk(rv == 32'(D) << 8, "R11 size", DW'(rv), DW'(D << 8));
  endtask

  task automatic t_disabled;
    for (int k = 0; k < 3; k++) in_write(k, mk(k));
    reg_write(8'h08, 32'h0003_0000);
    reg_read(8'h10, rv); chk(rv == 32'(D - 3) << 8, "R3 free after add", DW'(rv), DW'((D - 3) << 8));
    idle(6);
    chk(!job_valid, "R2 no start when disabled", DW'(job_valid), 0);
    @(negedge clk); job_done = 1'b1;
    @(negedge clk); job_done = 1'b0;
    reg_read(8'h14, rv); chk(rv == 0, "R10 idle done full", DW'(rv), 0);
    reg_read(8'h04, rv); chk(rv == 0, "R10 idle done status", DW'(rv), 0);
  endtask

  task automatic t_order;
    reg_write(8'h00, 32'h8000_0000);
    reg_read(8'h00, rv); chk(rv == 32'h8000_0000, "R2 enabled", DW'(rv), DW'(32'h8000_0000));
    for (int k = 0; k < 3; k++) run_job(mk(k));
    reg_read(8'h14, rv); chk(rv == 32'h300, "R6 full", DW'(rv), DW'(32'h300));
    reg_read(8'h10, rv); chk(rv == 32'(D) << 8, "R6 free", DW'(rv), DW'(D << 8));
    reg_read(8'h04, rv); chk(rv == 32'h8000_0000, "R6 done flag", DW'(rv), DW'(32'h8000_0000));
    chk(irq, "R9 irq pin", DW'(irq), 1);
    for (int k = 0; k < 3; k++) begin
      out_read(k, dv); chk(dv == mk(k), "R6 outbound entry", dv, mk(k));
    end
  endtask

  task automatic t_collide;
    reg_write(8'h04, 32'h8000_0000);
    reg_read(8'h04, rv); chk(rv == 0, "R9 clear", DW'(rv), 0);
    chk(!irq, "R9 irq low", DW'(irq), 0);
    in_write(3, mk(3));
    reg_write(8'h08, 32'h0001_0000);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (job_valid) break;
    end
    chk(job_desc == mk(3), "R5 job 3", job_desc, mk(3));
    job_done = 1'b1; reg_we = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h8000_0000;
    @(negedge clk); job_done = 1'b0; reg_we = 1'b0;
    owp = (owp + 1) % D;
    reg_read(8'h04, rv); chk(rv == 32'h8000_0000, "R9 set wins over clear", DW'(rv), DW'(32'h8000_0000));
    reg_read(8'h14, rv); chk(rv == 32'h400, "R6 full after collide", DW'(rv), DW'(32'h400));
  endtask

  task automatic t_remove;
    reg_write(8'h0C, 32'h0002_0000);
    reg_read(8'h14, rv); chk(rv == 32'h200, "R7 remove two", DW'(rv), DW'(32'h200));
    reg_write(8'h0C, 32'h0005_0000);
    reg_read(8'h14, rv); chk(rv == 0, "R7 remove clipped", DW'(rv), 0);
    reg_read(8'h04, rv); chk(rv == 32'hC000_0000, "R7 error flag", DW'(rv), DW'(32'hC000_0000));
    reg_write(8'h04, 32'hC000_0000);
    reg_read(8'h04, rv); chk(rv == 0, "R9 clear both", DW'(rv), 0);
  endtask

  task automatic t_clip_wrap;
    reg_write(8'h00, 32'h0);
    for (int k = 0; k < D; k++) in_write(k, mk(10 + k));
    reg_write(8'h08, 32'h000A_0000);
    reg_read(8'h10, rv); chk(rv == 0, "R4 add clipped", DW'(rv), 0);
    reg_read(8'h04, rv); chk(rv == 32'h4000_0000, "R4 error flag", DW'(rv), DW'(32'h4000_0000));
    reg_write(8'h04, 32'h4000_0000);
    reg_write(8'h00, 32'h8000_0000);
    for (int j = 0; j < D; j++) run_job(mk(10 + ((4 + j) % D)));
    reg_read(8'h14, rv); chk(rv == 32'(D) << 8, "R6 outbound full", DW'(rv), DW'(D << 8));
    out_read(0, dv); chk(dv == mk(10), "R5 wrapped outbound", dv, mk(10));
    out_read(7, dv); chk(dv == mk(17), "R6 outbound last", dv, mk(17));
  endtask

  task automatic t_backpressure;
    in_write(4, mk(30));
    reg_write(8'h08, 32'h0001_0000);
    idle(6);
    chk(!job_valid, "R8 stalled while full", DW'(job_valid), 0);
    reg_read(8'h10, rv); chk(rv == 32'(D - 1) << 8, "R3 free while stalled", DW'(rv), DW'((D - 1) << 8));
    reg_write(8'h0C, 32'h0001_0000);
    run_job(mk(30));
    out_read(4, dv); chk(dv == mk(30), "R8 resumed entry", dv, mk(30));
    reg_read(8'h14, rv); chk(rv == 32'(D) << 8, "R8 full again", DW'(rv), DW'(D << 8));
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset;
    t_disabled;
    t_order;
    t_collide;
    t_remove;
    t_clip_wrap;
    t_backpressure;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule